// File: doc/BRIEF.md
# Root Port Power-Management Event Tracker

This block keeps the power-management event state of one root port. It holds a 16-bit root control register and a 32-bit root status register. The status register reports the requester ID of the most recent power-management event (PME), a PME status flag and a PME pending flag. Requesters arrive as a one-cycle injection pulse that carries a bus, device and function number. While an earlier event has not been acknowledged, one further requester waits in a single-entry slot. A write-1 acknowledge of the status flag moves that waiting requester into the status register and does not clear the flag. The flag is cleared only when the slot is empty.

Hot-plug events enter on their own input. An external power-state input says whether PME wake is armed. When it is armed, a hot-plug event does not interrupt at once: the block files a PME carrying the port's own requester ID and holds the hot-plug interrupt back. It releases that interrupt when an acknowledge finds the slot empty. Both interrupt requests leave the block as one-cycle pulses. Message transport and interrupt message formatting are handled elsewhere.

Top module: `pme_root_tracker`

## Requirements
- R1: After reset, `rd_ctrl` and `rd_stat` read zero, the slot is empty, no hot-plug interrupt is held back, and both interrupt outputs are low.
- R2: `rd_stat[15:0]` holds the requester ID packed as bus in bits 15:8, device in bits 7:3 and function in bits 2:0. `rd_stat[16]` is PME status, `rd_stat[17]` is PME pending, and bits 31:18 always read zero.
- R3: An injection while PME status is clear loads the new requester ID over the old one and sets PME status. Both are visible in `rd_stat` one cycle later.
- R4: An injection while PME status is set leaves status and ID unchanged. It sets PME pending and places the requester in the slot, replacing any requester already waiting there.
- R5: A full-word status write with bit 16 set, while PME pending is set, loads the waiting ID, clears pending, empties the slot and keeps PME status set.
- R6: The same acknowledge with PME pending clear clears PME status and keeps the ID. If a hot-plug interrupt was held back, the block drops the hold and pulses `hp_irq` for one cycle, one cycle later.
- R7: `pme_irq` pulses for one cycle, one cycle after an injection that loads a new ID or an acknowledge that promotes a waiting ID. It pulses only if root control bit 3 (PME interrupt enable) was set at the start of that cycle.
- R8: With `pme_armed` low, `hp_event` pulses `hp_irq` one cycle later. With `pme_armed` high, `hp_event` holds the hot-plug interrupt back and injects a PME carrying the port's own ID (parameters `OWN_BUS`, `OWN_DEV`, `OWN_FN`).
- R9: A root control write (`wr_sel`=0) takes effect only when `wr_strb[1:0]` are both set. A root status write (`wr_sel`=1) takes effect only when all four `wr_strb` bits are set. Any other write changes nothing.
- R10: Events in the same cycle are applied in a fixed order: the acknowledge first, then the hot-plug-generated injection, then the external injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects root control, 1 selects root status |
| wr_strb | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| pme_inj | input | 1 | One-cycle PME injection pulse |
| inj_bus | input | 8 | Requester bus number |
| inj_dev | input | 5 | Requester device number |
| inj_fn | input | 3 | Requester function number |
| hp_event | input | 1 | One-cycle hot-plug event pulse |
| pme_armed | input | 1 | PME wake armed by the power-state logic |
| rd_ctrl | output | 16 | Root control register |
| rd_stat | output | 32 | Root status register |
| pme_irq | output | 1 | One-cycle PME interrupt request |
| hp_irq | output | 1 | One-cycle hot-plug interrupt request |

## Verification
The per-event properties assume that no other event lands in the same cycle. The injection and acknowledge checks therefore fire only when `hp_event` is low, and the merged orderings of R10 are left to the directed vectors. The properties also assume that `inj_bus`, `inj_dev` and `inj_fn` are valid in the cycle of `pme_inj`. The stimulus drives every input for exactly one cycle from the falling edge and returns it to idle, so each pulse is a single-cycle event. The same-cycle combinations are applied only in the vectors written for R10.

// File: rtl/pme_pkg.sv
package pme_pkg;
    localparam int BUS_W      = 8;
    localparam int DEV_W      = 5;
    localparam int FN_W       = 3;
    localparam int RID_W      = BUS_W + DEV_W + FN_W;
    localparam int CTRL_W     = 16;
    localparam int STAT_W     = 32;
    localparam int STRB_W     = STAT_W / 8;
    localparam int CTRL_STRB  = CTRL_W / 8;
    localparam int STAT_BIT   = RID_W;
    localparam int PEND_BIT   = RID_W + 1;
    localparam int PME_IE_BIT = 3;
    localparam int NSRC       = 2;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [RID_W-1:0]  rid;
        logic              stat;
        logic              pend;
        logic [RID_W-1:0]  slot;
        logic              defer;
        logic              pirq;
        logic              hirq;
    } trk_t;
endpackage

// File: rtl/pme_rid_pack.sv
module pme_rid_pack #(
    parameter int BW = 8,
    parameter int DW = 5,
    parameter int FW = 3,
    localparam int OW = BW + DW + FW
) (
    input  logic [BW-1:0] bus,
    input  logic [DW-1:0] dev,
    input  logic [FW-1:0] fn,
    output logic [OW-1:0] rid
);
    assign rid = {bus, dev, fn};
endmodule

// File: rtl/pme_wr_decode.sv
module pme_wr_decode
    import pme_pkg::*;
(
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic [STAT_W-1:0] wr_data,
    output logic              ctrl_we,
    output logic [CTRL_W-1:0] ctrl_val,
    output logic              ack
);
    logic unused_hi;

    assign ctrl_we   = wr_en && !wr_sel && (&wr_strb[CTRL_STRB-1:0]);
    assign ctrl_val  = wr_data[CTRL_W-1:0];
    assign ack       = wr_en && wr_sel && (&wr_strb) && wr_data[STAT_BIT];
    assign unused_hi = ^{wr_data[STAT_W-1:PEND_BIT], wr_data[STAT_BIT-1:CTRL_W]};
endmodule

// File: rtl/pme_root_tracker.sv
module pme_root_tracker
    import pme_pkg::*;
#(
    parameter logic [7:0] OWN_BUS = 8'h00,
    parameter logic [4:0] OWN_DEV = 5'd2,
    parameter logic [2:0] OWN_FN  = 3'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [3:0]  wr_strb,
    input  logic [31:0] wr_data,
    input  logic        pme_inj,
    input  logic [7:0]  inj_bus,
    input  logic [4:0]  inj_dev,
    input  logic [2:0]  inj_fn,
    input  logic        hp_event,
    input  logic        pme_armed,
    output logic [15:0] rd_ctrl,
    output logic [31:0] rd_stat,
    output logic        pme_irq,
    output logic        hp_irq
);
    trk_t st_d, st_q;

    logic              ctrl_we, ack;
    logic [CTRL_W-1:0] ctrl_val;
    logic [RID_W-1:0]  src_rid [NSRC];
    logic [NSRC-1:0]   src_v;

    pme_wr_decode u_dec (
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_strb  (wr_strb),
        .wr_data  (wr_data),
        .ctrl_we  (ctrl_we),
        .ctrl_val (ctrl_val),
        .ack      (ack)
    );

    // Source 0: wake-armed hot-plug (own ID); source 1: external injection.
    pme_rid_pack #(.BW(BUS_W), .DW(DEV_W), .FW(FN_W)) u_own_rid (
        .bus (OWN_BUS), .dev (OWN_DEV), .fn (OWN_FN), .rid (src_rid[0])
    );
    pme_rid_pack #(.BW(BUS_W), .DW(DEV_W), .FW(FN_W)) u_ext_rid (
        .bus (inj_bus), .dev (inj_dev), .fn (inj_fn), .rid (src_rid[1])
    );

    assign src_v = {pme_inj, hp_event && pme_armed};

    always_comb begin
        logic ev;
        st_d      = st_q;
        st_d.pirq = 1'b0;
        st_d.hirq = 1'b0;
        ev        = 1'b0;

        if (ctrl_we) st_d.ctrl = ctrl_val;

        // Acknowledge comes first in a shared cycle.
        if (ack) begin
            if (st_q.pend) begin
                st_d.rid  = st_q.slot;
                st_d.pend = 1'b0;
                st_d.slot = '0;
                ev        = 1'b1;
            end else begin
                st_d.stat = 1'b0;
                if (st_q.defer) begin
                    st_d.defer = 1'b0;
                    st_d.hirq  = 1'b1;
                end
            end
        end

        if (hp_event && !pme_armed) st_d.hirq  = 1'b1;
        if (hp_event && pme_armed)  st_d.defer = 1'b1;

        for (int i = 0; i < NSRC; i++) begin
            if (src_v[i]) begin
                if (st_d.stat) begin
                    st_d.pend = 1'b1;
                    st_d.slot = src_rid[i];
                end else begin
                    st_d.rid  = src_rid[i];
                    st_d.stat = 1'b1;
                    ev        = 1'b1;
                end
            end
        end

        st_d.pirq = ev && st_q.ctrl[PME_IE_BIT] && st_d.stat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_ctrl = st_q.ctrl;
    assign rd_stat = {{(STAT_W-PEND_BIT-1){1'b0}}, st_q.pend, st_q.stat, st_q.rid};
    assign pme_irq = st_q.pirq;
    assign hp_irq  = st_q.hirq;
endmodule

// File: rtl/pme_root_tracker_chk.sv
module pme_root_tracker_chk
    import pme_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [3:0]  wr_strb,
    input logic [31:0] wr_data,
    input logic        pme_inj,
    input logic [7:0]  inj_bus,
    input logic [4:0]  inj_dev,
    input logic [2:0]  inj_fn,
    input logic        hp_event,
    input logic        pme_armed,
    input logic [15:0] rd_ctrl,
    input logic [31:0] rd_stat,
    input logic        pme_irq,
    input logic        hp_irq
);
    logic ack_in;
    assign ack_in = wr_en && wr_sel && (wr_strb == 4'hF) && wr_data[STAT_BIT];

    // R2
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat[STAT_W-1:PEND_BIT+1] == '0);

    // R4
    pend_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat[PEND_BIT] |-> rd_stat[STAT_BIT]);

    // R3
    load_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pme_inj && !hp_event && !ack_in && !rd_stat[STAT_BIT]) |=>
        (rd_stat[STAT_BIT] && rd_stat[RID_W-1:0] == {$past(inj_bus), $past(inj_dev), $past(inj_fn)}));

    // R4
    hold_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pme_inj && !hp_event && !ack_in && rd_stat[STAT_BIT]) |=>
        (rd_stat[PEND_BIT] && rd_stat[RID_W-1:0] == $past(rd_stat[RID_W-1:0])));

    // R5
    promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && rd_stat[PEND_BIT] && !pme_inj && !hp_event) |=>
        (rd_stat[STAT_BIT] && !rd_stat[PEND_BIT]));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && !rd_stat[PEND_BIT] && !pme_inj && !hp_event) |=>
        (!rd_stat[STAT_BIT] && rd_stat[RID_W-1:0] == $past(rd_stat[RID_W-1:0])));

    // R7
    pirq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pme_irq |-> (rd_stat[STAT_BIT] && $past(rd_ctrl[PME_IE_BIT])));

    // R8
    hirq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_irq |-> ($past(hp_event && !pme_armed) || $past(ack_in && !rd_stat[PEND_BIT])));
endmodule

bind pme_root_tracker pme_root_tracker_chk u_chk (.*);

// File: tb/tb_pme_root_tracker.sv
module tb_pme_root_tracker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_sel;
    logic [3:0]  wr_strb;
    logic [31:0] wr_data;
    logic        pme_inj;
    logic [7:0]  inj_bus;
    logic [4:0]  inj_dev;
    logic [2:0]  inj_fn;
    logic        hp_event, pme_armed;
    logic [15:0] rd_ctrl;
    logic [31:0] rd_stat;
    logic        pme_irq, hp_irq;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pme_root_tracker dut (.*);

    typedef struct packed {
        logic        inj;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic        hp;
        logic        arm;
        logic        we;
        logic        sel;
        logic [3:0]  strb;
        logic [31:0] data;
        logic [15:0] ectrl;
        logic [31:0] estat;
        logic        epirq;
        logic        ehirq;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h3, 32'h0000_0008, 16'h0008, 32'h0000_0000, 1'b0, 1'b0, 8'd9 },  // R9 ctrl write
        '{1'b1, 8'h03, 5'd4, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 32'h0,        16'h0008, 32'h0001_0325, 1'b1, 1'b0, 8'd3 },  // R3 load
        '{1'b1, 8'h12, 5'd1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 32'h0,        16'h0008, 32'h0003_0325, 1'b0, 1'b0, 8'd4 },  // R4 queue
        '{1'b1, 8'h20, 5'd0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 32'h0,        16'h0008, 32'h0003_0325, 1'b0, 1'b0, 8'd4 },  // R4 replace slot
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0001_0000, 16'h0008, 32'h0001_2007, 1'b1, 1'b0, 8'd5 }, // R5 promote
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h3, 32'h0001_0000, 16'h0008, 32'h0001_2007, 1'b0, 1'b0, 8'd9 }, // R9 partial ack
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0001_0000, 16'h0008, 32'h0000_2007, 1'b0, 1'b0, 8'd6 }, // R6 clear
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 32'h0,        16'h0008, 32'h0000_2007, 1'b0, 1'b1, 8'd8 },  // R8 direct hp
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 32'h0,        16'h0008, 32'h0001_0010, 1'b1, 1'b0, 8'd8 },  // R8 armed hp
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0001_0000, 16'h0008, 32'h0000_0010, 1'b0, 1'b1, 8'd6 }, // R6 release
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0001_0000, 16'h0008, 32'h0000_0010, 1'b0, 1'b0, 8'd6 }, // R6 no re-release
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h3, 32'h0000_0000, 16'h0000, 32'h0000_0010, 1'b0, 1'b0, 8'd9 }, // R9
        '{1'b1, 8'h01, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 32'h0,        16'h0000, 32'h0001_0100, 1'b0, 1'b0, 8'd7 },  // R7 disabled
        '{1'b1, 8'h02, 5'd3, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0001_0000, 16'h0000, 32'h0001_0219, 1'b0, 1'b0, 8'd10}, // R10 ack+inj
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h3, 32'h0000_0008, 16'h0008, 32'h0001_0219, 1'b0, 1'b0, 8'd9 }, // R9
        '{1'b1, 8'h05, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 32'h0,        16'h0008, 32'h0003_0219, 1'b0, 1'b0, 8'd4 },  // R4
        '{1'b1, 8'h06, 5'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0001_0000, 16'h0008, 32'h0003_0500, 1'b1, 1'b0, 8'd10}, // R10 promote+queue
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h1, 32'h0000_0000, 16'h0008, 32'h0003_0500, 1'b0, 1'b0, 8'd9 }, // R9 byte write
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 32'h0,        16'h0008, 32'h0003_0500, 1'b0, 1'b0, 8'd8 },  // R8 armed, busy
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0001_0000, 16'h0008, 32'h0001_0010, 1'b1, 1'b0, 8'd5 }, // R5 hold kept
        '{1'b0, 8'h00, 5'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0001_0000, 16'h0008, 32'h0000_0010, 1'b0, 1'b1, 8'd6 }  // R6 release
    };

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_sel = 0; wr_strb = 0; wr_data = 0;
        pme_inj = 0; inj_bus = 0; inj_dev = 0; inj_fn = 0;
        hp_event = 0; pme_armed = 0;
    endtask

    task automatic check_all(string rq, logic [15:0] ec, logic [31:0] es, logic ep, logic eh);
        chk(rq, "rd_ctrl", {16'h0, rd_ctrl}, {16'h0, ec});
        chk(rq, "rd_stat", rd_stat, es);
        chk(rq, "pme_irq", {31'h0, pme_irq}, {31'h0, ep});
        chk(rq, "hp_irq",  {31'h0, hp_irq},  {31'h0, eh});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check_all("R1", 16'h0, 32'h0, 1'b0, 1'b0);  // R1 reset state

        for (int i = 0; i < NV; i++) begin
            inj_bus = VEC[i].bus; inj_dev = VEC[i].dev; inj_fn = VEC[i].fn;
            pme_inj = VEC[i].inj; hp_event = VEC[i].hp; pme_armed = VEC[i].arm;
            wr_en = VEC[i].we; wr_sel = VEC[i].sel; wr_strb = VEC[i].strb; wr_data = VEC[i].data;
            @(posedge clk);
            @(negedge clk);
            idle();
            check_all($sformatf("R%0d", VEC[i].rq), VEC[i].ectrl, VEC[i].estat, VEC[i].epirq, VEC[i].ehirq);
        end

        // R7: pulse lasts a single cycle
        @(posedge clk);
        @(negedge clk);
        check_all("R7", 16'h0008, 32'h0000_0010, 1'b0, 1'b0);

        // R1: reset from a busy state (status, pending and a held hot-plug)
        pme_inj = 1; inj_bus = 8'h33;
        @(posedge clk); @(negedge clk);
        pme_inj = 0; hp_event = 1; pme_armed = 1;
        @(posedge clk); @(negedge clk);
        idle();
        chk("R4", "rd_stat", rd_stat, 32'h0003_3300);
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        rst_n = 1;
        check_all("R1", 16'h0, 32'h0, 1'b0, 1'b0);
        // R1: no hold survives reset, so an ack releases nothing
        wr_en = 1; wr_sel = 1; wr_strb = 4'hF; wr_data = 32'h0001_0000;
        @(posedge clk); @(negedge clk);
        idle();
        check_all("R1", 16'h0, 32'h0, 1'b0, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule